// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block measures how fast a target clock runs compared with a reference clock. Both clocks reach the block as level signals and are sampled by the system clock `clk`. A small register bus selects the sources, the dividers, the reference edge mode, the reference filter, the two count limits and how faults are reported. It also holds the start bit.

The reference is optionally filtered and then divided. Its qualified edges mark the bounds of back-to-back measurement windows. Inside each window, prescaled target edges are counted into a saturating counter of `CNT_W` bits (16 by default). When a window closes, the count is latched and compared with the limits. Three sticky flags are updated: error, end and overflow. The flags drive an interrupt line and a reset-request line.

Software programs the configuration while stopped, sets the start bit, then polls the flags or waits for the interrupt. It reads the latched count and clears the flags by writing ones. The block has no streaming data path. Every pin is a plain control or status signal, so no back-pressure rules apply.

Top module: `freq_window_monitor`

## Requirements
- R1: The target source is picked by register 1 bits [3:2], and its rising edges are prescaled by register 1 bits [1:0]. The codes 0, 1, 2 and 3 give ratios of 1, 4, 8 and 32.
- R2: Register 2 bits [1:0] divide the reference by 32, 128, 1024 or 8192 (codes 0 to 3). The qualified edges of the divided reference bound consecutive windows, and each window holds exactly the prescaled target pulses that fall between two such edges.
- R3: Register 2 bits [3:2] choose the qualifying edge of the divided reference: 0 selects rising, 1 selects falling, 2 selects both, and 3 selects none.
- R4: Register 2 bits [5:4] set the filter mode: 0 is off, and 1, 2 and 3 sample at `clk` divided by 1, 4 or 16. With the filter on, a new reference level is accepted only after three consecutive equal samples.
- R5: Register 2 bit [6] set to 1 routes the external reference input. Otherwise the internal source picked by register 2 bits [8:7] is used.
- R6: While the start bit (register 0 bit 0) is 1, windows repeat back to back. The first qualified edge after start only opens a window. At each close the count is latched and can be read at address 7.
- R7: Each window close sets the end flag (status, address 6, bit 1). It sets the error flag (bit 0) when the count is below the lower limit (address 3) or above the upper limit (address 4).
- R8: The counter saturates at all ones. A pulse that arrives when the counter is already saturated sets the overflow flag (bit 2) at the close of that window.
- R9: Writing address 7 clears each flag whose data bit is 1 (bit 0 error, bit 1 end, bit 2 overflow). A flag being set in the same cycle wins over the clear.
- R10: `irq_o` is the OR of each flag ANDed with its enable in register 5 (bit 0 error, bit 1 end, bit 2 overflow). The error flag takes part only while the action bit (register 5 bit 3) is 0.
- R11: `rst_req_o` is high while the error flag is set, the action bit is 1, and the reset enable (register 5 bit 4) is 1.
- R12: After reset, every register and flag reads zero and both outputs are low. Clearing the start bit stops the counting and disarms the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| tgt_clks_i | input | NSRC | Candidate target clock levels |
| ref_clks_i | input | NSRC | Candidate internal reference clock levels |
| ref_ext_i | input | 1 | External reference level |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |

## Verification
A wrong prescaler or divider state shows up as a latched count that is off by a fixed factor. It appears at the first window close after start, a few thousand cycles later at most. Window partitioning errors, such as losing or double-counting the pulse that coincides with a window edge, give counts that are off by one. The bench uses target and reference periods that divide every window exactly, so the expected count is a single value and not a range. Flag and output routing faults show on `irq_o`, `rst_req_o` or the status read in the same cycle the end flag rises.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  localparam int ADDR_W    = 3;
  localparam int DIVCNT_W  = 13;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TGT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd4;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd7;

  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH, EDGE_NONE} edge_mode_e;
  typedef enum logic [1:0] {FLT_OFF, FLT_DIV1, FLT_DIV4, FLT_DIV16} flt_mode_e;

  typedef struct packed {
    logic rst_en;
    logic act_rst;
    logic ie_ovf;
    logic ie_end;
    logic ie_err;
  } irq_cfg_t;

  // prescale limit (ratio - 1) for the target path
  function automatic logic [4:0] tgt_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return 5'd3;
      2'd2:    return 5'd7;
      default: return 5'd31;
    endcase
  endfunction

  // edge-counter bit whose toggling divides the reference
  function automatic int unsigned ref_bit(input logic [1:0] code);
    case (code)
      2'd0:    return 4;
      2'd1:    return 6;
      2'd2:    return 9;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/fwm_sync.sv
module fwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fwm_tgt_prescale.sv
module fwm_tgt_prescale import fwm_pkg::*; #(
  parameter int NSRC        = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  clks_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       div_i,
  output logic             tick_o
);
  logic       lvl, lvl_q;
  logic [4:0] pre_q;
  logic [4:0] limit;

  fwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(clks_i[sel_i]), .q_o(lvl)
  );

  assign limit = tgt_limit(div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pre_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      tick_o <= 1'b0;
      if (lvl && !lvl_q) begin
        if (pre_q >= limit) begin
          pre_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          pre_q <= pre_q + 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fwm_ref_window.sv
module fwm_ref_window import fwm_pkg::*; #(
  parameter int NSRC        = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  clks_i,
  input  logic             ext_i,
  input  logic             ext_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  flt_mode_e        flt_i,
  input  logic [1:0]       div_i,
  input  edge_mode_e       edge_i,
  output logic             edge_o
);
  logic                raw, synced, level, lvl_q;
  logic [3:0]          smp_cnt_q;
  logic                smp_en;
  logic [1:0]          hist_q;
  logic                flt_q;
  logic [DIVCNT_W-1:0] edgecnt_q;
  logic                div_lvl, div_q, qual;

  assign raw = ext_en_i ? ext_i : clks_i[sel_i];

  fwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  always_comb begin
    case (flt_i)
      FLT_DIV1:  smp_en = 1'b1;
      FLT_DIV4:  smp_en = (smp_cnt_q[1:0] == 2'd0);
      FLT_DIV16: smp_en = (smp_cnt_q == 4'd0);
      default:   smp_en = 1'b0;
    endcase
  end

  assign level   = (flt_i == FLT_OFF) ? synced : flt_q;
  assign div_lvl = edgecnt_q[ref_bit(div_i)];

  always_comb begin
    case (edge_i)
      EDGE_RISE: qual = div_lvl & ~div_q;
      EDGE_FALL: qual = ~div_lvl & div_q;
      EDGE_BOTH: qual = div_lvl ^ div_q;
      default:   qual = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt_q <= '0;
      hist_q    <= '0;
      flt_q     <= 1'b0;
      lvl_q     <= 1'b0;
      edgecnt_q <= '0;
      div_q     <= 1'b0;
      edge_o    <= 1'b0;
    end else begin
      smp_cnt_q <= smp_cnt_q + 4'd1;
      if (smp_en) begin
        hist_q <= {hist_q[0], synced};
        if (hist_q == {2{synced}} && synced != flt_q) flt_q <= synced;
      end
      lvl_q <= level;
      if (level && !lvl_q) edgecnt_q <= edgecnt_q + 1'b1;
      div_q  <= div_lvl;
      edge_o <= qual;
    end
  end
endmodule

// File: rtl/fwm_regs.sv
module fwm_regs import fwm_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [2:0]        flags_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              start_o,
  output logic [SEL_W-1:0]  tsrc_o,
  output logic [1:0]        tdiv_o,
  output logic [SEL_W-1:0]  rsrc_o,
  output logic [1:0]        rdiv_o,
  output edge_mode_e        edge_o,
  output flt_mode_e         flt_o,
  output logic              ext_en_o,
  output logic [CNT_W-1:0]  lo_o,
  output logic [CNT_W-1:0]  hi_o,
  output irq_cfg_t          icfg_o,
  output logic [2:0]        clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      tsrc_o   <= '0;
      tdiv_o   <= '0;
      rsrc_o   <= '0;
      rdiv_o   <= '0;
      edge_o   <= EDGE_RISE;
      flt_o    <= FLT_OFF;
      ext_en_o <= 1'b0;
      lo_o     <= '0;
      hi_o     <= '0;
      icfg_o   <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: start_o <= wdata_i[0];
        A_TGT: begin
          tdiv_o <= wdata_i[1:0];
          tsrc_o <= wdata_i[2 +: SEL_W];
        end
        A_REF: begin
          rdiv_o   <= wdata_i[1:0];
          edge_o   <= edge_mode_e'(wdata_i[3:2]);
          flt_o    <= flt_mode_e'(wdata_i[5:4]);
          ext_en_o <= wdata_i[6];
          rsrc_o   <= wdata_i[7 +: SEL_W];
        end
        A_LO:   lo_o   <= wdata_i[CNT_W-1:0];
        A_HI:   hi_o   <= wdata_i[CNT_W-1:0];
        A_IRQ:  icfg_o <= irq_cfg_t'(wdata_i[4:0]);
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == A_CLR) ? wdata_i[2:0] : 3'b000;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[0] = start_o;
      A_TGT: begin
        rdata_o[1:0]        = tdiv_o;
        rdata_o[2 +: SEL_W] = tsrc_o;
      end
      A_REF: begin
        rdata_o[1:0]        = rdiv_o;
        rdata_o[3:2]        = edge_o;
        rdata_o[5:4]        = flt_o;
        rdata_o[6]          = ext_en_o;
        rdata_o[7 +: SEL_W] = rsrc_o;
      end
      A_LO:    rdata_o[CNT_W-1:0] = lo_o;
      A_HI:    rdata_o[CNT_W-1:0] = hi_o;
      A_IRQ:   rdata_o[4:0]       = icfg_o;
      A_STAT:  rdata_o[2:0]       = flags_i;
      default: rdata_o[CNT_W-1:0] = count_i;
    endcase
  end
endmodule

// File: rtl/freq_window_monitor.sv
module freq_window_monitor import fwm_pkg::*; #(
  parameter int NSRC        = 4,
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NSRC-1:0]   tgt_clks_i,
  input  logic [NSRC-1:0]   ref_clks_i,
  input  logic              ref_ext_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             cfg_start, cfg_ext_en;
  logic [SEL_W-1:0] cfg_tsrc, cfg_rsrc;
  logic [1:0]       cfg_tdiv, cfg_rdiv;
  edge_mode_e       cfg_edge;
  flt_mode_e        cfg_flt;
  logic [CNT_W-1:0] cfg_lo, cfg_hi;
  irq_cfg_t         icfg;
  logic [2:0]       clr_mask;

  logic             tgt_tick, win_edge, close_evt, out_of_range;
  logic             armed_q, ovf_pend_q;
  logic [CNT_W-1:0] cnt_q, count_q;
  logic [2:0]       flags_q, set_v;   // bit0 error, bit1 end, bit2 overflow

  fwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .flags_i(flags_q),
    .count_i(count_q), .start_o(cfg_start), .tsrc_o(cfg_tsrc),
    .tdiv_o(cfg_tdiv), .rsrc_o(cfg_rsrc), .rdiv_o(cfg_rdiv),
    .edge_o(cfg_edge), .flt_o(cfg_flt), .ext_en_o(cfg_ext_en),
    .lo_o(cfg_lo), .hi_o(cfg_hi), .icfg_o(icfg), .clr_o(clr_mask)
  );

  fwm_tgt_prescale #(.NSRC(NSRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_tgt (
    .clk(clk), .rst_n(rst_n), .clks_i(tgt_clks_i), .sel_i(cfg_tsrc),
    .div_i(cfg_tdiv), .tick_o(tgt_tick)
  );

  fwm_ref_window #(.NSRC(NSRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk(clk), .rst_n(rst_n), .clks_i(ref_clks_i), .ext_i(ref_ext_i),
    .ext_en_i(cfg_ext_en), .sel_i(cfg_rsrc), .flt_i(cfg_flt),
    .div_i(cfg_rdiv), .edge_i(cfg_edge), .edge_o(win_edge)
  );

  assign close_evt    = cfg_start && armed_q && win_edge;
  assign out_of_range = (cnt_q < cfg_lo) || (cnt_q > cfg_hi);
  assign set_v        = close_evt ? {ovf_pend_q, 1'b1, out_of_range} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      count_q    <= '0;
      ovf_pend_q <= 1'b0;
      flags_q    <= '0;
    end else begin
      if (!cfg_start) begin
        armed_q    <= 1'b0;
        cnt_q      <= '0;
        ovf_pend_q <= 1'b0;
      end else if (win_edge) begin
        // the pulse coinciding with the edge belongs to the new window
        armed_q    <= 1'b1;
        cnt_q      <= tgt_tick ? CNT_W'(1) : '0;
        ovf_pend_q <= 1'b0;
        if (armed_q) count_q <= cnt_q;
      end else if (tgt_tick) begin
        if (cnt_q == CNT_MAX) ovf_pend_q <= 1'b1;
        else                  cnt_q      <= cnt_q + 1'b1;
      end
      flags_q <= (flags_q & ~clr_mask) | set_v;
    end
  end

  assign irq_o     = (flags_q[0] & icfg.ie_err & ~icfg.act_rst) |
                     (flags_q[1] & icfg.ie_end) |
                     (flags_q[2] & icfg.ie_ovf);
  assign rst_req_o = flags_q[0] & icfg.act_rst & icfg.rst_en;
endmodule

// File: rtl/freq_window_monitor_chk.sv
module freq_window_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             win_edge_i,
  input logic             tick_i,
  input logic             armed_i,
  input logic             ovf_pend_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [2:0]       flags_i,
  input logic [2:0]       clr_i,
  input logic             ie_err_i,
  input logic             ie_end_i,
  input logic             ie_ovf_i,
  input logic             irq_i,
  input logic             rst_req_i
);
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !win_edge_i && cnt_i == {CNT_W{1'b1}}) |=> cnt_i == {CNT_W{1'b1}}); // R8

  AST_OVF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !win_edge_i && tick_i && cnt_i == {CNT_W{1'b1}}) |=> ovf_pend_i); // R8

  AST_END_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && armed_i && win_edge_i) |=> flags_i[1]); // R7

  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!armed_i && cnt_i == '0)); // R12

  AST_CLEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[1] && !(start_i && armed_i && win_edge_i)) |=> !flags_i[1]); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_err_i && !ie_end_i && !ie_ovf_i) |-> !irq_i); // R10

  AST_RSTREQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> flags_i[0]); // R11
endmodule

bind freq_window_monitor freq_window_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(cfg_start), .win_edge_i(win_edge),
  .tick_i(tgt_tick), .armed_i(armed_q), .ovf_pend_i(ovf_pend_q),
  .cnt_i(cnt_q), .flags_i(flags_q), .clr_i(clr_mask),
  .ie_err_i(icfg.ie_err), .ie_end_i(icfg.ie_end), .ie_ovf_i(icfg.ie_ovf),
  .irq_i(irq_o), .rst_req_i(rst_req_o)
);

// File: tb/freq_window_monitor_tb_top.sv
`timescale 1ns/1ps
module freq_window_monitor_tb_top;
  localparam int NSRC  = 4;
  localparam int CNT_W = 10;

  typedef struct packed {
    logic [1:0]  tsrc;
    logic [1:0]  tdiv;
    logic [1:0]  rsrc;
    logic [1:0]  rdiv;
    logic [1:0]  edm;
    logic [1:0]  flt;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] cnt;
    logic        err;
  } vec_t;

  // target periods: src0 4 clk, src1 2 clk, src2 8 clk; reference src0 16 clk, src1 32 clk
  localparam vec_t VECS [0:8] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 16'd100, 16'd200,  16'd128, 1'b0},
    '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 16'd33,  16'd40,   16'd32,  1'b1},
    '{2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 16'd0,   16'd31,   16'd32,  1'b1},
    '{2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 16'd8,   16'd8,    16'd8,   1'b0},
    '{2'd2, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 16'd256, 16'd256,  16'd256, 1'b0},
    '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 16'd0,   16'd1023, 16'd128, 1'b0},
    '{2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 16'd65,  16'd100,  16'd64,  1'b1},
    '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 16'd0,   16'd1023, 16'd256, 1'b0},
    '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 16'd0,   16'd1023, 16'd32,  1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_we = 1'b0;
  logic [2:0]      bus_addr = 3'd0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic [NSRC-1:0] tgt_clks = '0;
  logic [NSRC-1:0] ref_clks = '0;
  logic            ref_ext = 1'b0;
  logic            irq, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  freq_window_monitor #(.NSRC(NSRC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tgt_clks_i(tgt_clks),
    .ref_clks_i(ref_clks), .ref_ext_i(ref_ext), .irq_o(irq), .rst_req_o(rst_req)
  );

  initial forever #2.5 clk = ~clk;

  initial begin
    int unsigned ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      tgt_clks[0] = (ph % 4) < 2;
      tgt_clks[1] = ph[0];
      tgt_clks[2] = (ph % 8) < 4;
      ref_clks[0] = (ph % 16) < 8;
      ref_clks[1] = (ph % 32) < 16;
      ref_ext     = (ph % 16) < 8;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_end(input int limit, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      bus_addr = 3'd6;
      #1;
      if (bus_rdata[1]) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic setup(input logic [15:0] tcfg, input logic [15:0] rcfg,
                       input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] icfg);
    wr(3'd0, 16'd0);
    wr(3'd7, 16'd7);
    wr(3'd1, tcfg);
    wr(3'd2, rcfg);
    wr(3'd3, lo);
    wr(3'd4, hi);
    wr(3'd5, icfg);
    repeat (8) @(negedge clk);
    wr(3'd0, 16'd1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit seen;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(3'd6, d); check(d == 16'd0, "R12 status after reset", d, 0);
    rd(3'd7, d); check(d == 16'd0, "R12 count after reset", d, 0);
    rd(3'd2, d); check(d == 16'd0, "R12 ref config after reset", d, 0);
    check(irq == 1'b0 && rst_req == 1'b0, "R12 outputs after reset", {irq, rst_req}, 0);

    // vector table: R1 prescale, R2 divide, R3 edge, R4 filter, R6 count, R7 error
    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      setup({12'd0, v.tsrc, v.tdiv},
            {7'd0, v.rsrc, 1'b0, v.flt, v.edm, v.rdiv},
            v.lo, v.hi, 16'd0);
      wait_end(6000, seen);
      check(seen, "R7 end flag raised", seen, 1);
      rd(3'd7, d);
      check(d == v.cnt, "R1 R2 R3 R4 R6 latched count", d, v.cnt);
      rd(3'd6, d);
      check(d[0] == v.err, "R7 error flag vs limits", d[0], v.err);
    end

    // R8 overflow: 1024 pulses into a 10-bit counter
    setup(16'd4, 16'd1, 16'd0, 16'd1023, 16'd4);
    wait_end(6000, seen);
    rd(3'd6, d);
    check(d[2] == 1'b1, "R8 overflow flag", d[2], 1);
    rd(3'd7, d);
    check(d == 16'd1023, "R8 saturated count", d, 1023);
    check(irq == 1'b1, "R10 overflow interrupt", irq, 1);

    // R9 clear overflow only, end stays
    wr(3'd0, 16'd0);
    wr(3'd7, 16'd4);
    rd(3'd6, d);
    check(d[2:0] == 3'b010, "R9 selective clear", d[2:0], 2);
    check(irq == 1'b0, "R10 interrupt drops after clear", irq, 0);
    wr(3'd7, 16'd2);
    rd(3'd6, d);
    check(d[2:0] == 3'b000, "R9 clear end", d[2:0], 0);

    // R11 error routed to reset request (count 32 below lower limit 33)
    setup(16'd1, 16'd0, 16'd33, 16'd40, 16'h19);
    wait_end(6000, seen);
    rd(3'd6, d);
    check(rst_req == 1'b1, "R11 reset request on error", rst_req, 1);
    check(irq == 1'b0, "R10 error not on irq when action is reset", irq, 0);

    setup(16'd1, 16'd0, 16'd33, 16'd40, 16'h09);
    wait_end(6000, seen);
    rd(3'd6, d);
    check(rst_req == 1'b0, "R11 reset request gated by enable", rst_req, 0);

    setup(16'd1, 16'd0, 16'd33, 16'd40, 16'h01);
    wait_end(6000, seen);
    rd(3'd6, d);
    check(irq == 1'b1, "R10 error interrupt", irq, 1);

    // R5 internal constant source: no windows; external source: windows
    setup(16'd0, 16'd256, 16'd0, 16'd1023, 16'd0);
    repeat (1500) @(negedge clk);
    rd(3'd6, d);
    check(d[1] == 1'b0, "R5 idle internal source gives no end", d[1], 0);
    setup(16'd0, 16'd320, 16'd0, 16'd1023, 16'd0);
    wait_end(6000, seen);
    rd(3'd7, d);
    check(seen && d == 16'd128, "R5 external reference count", d, 128);

    // R4 divide-by-16 filter suppresses an 8-cycle-high reference
    setup(16'd0, 16'd48, 16'd0, 16'd1023, 16'd0);
    repeat (1500) @(negedge clk);
    rd(3'd6, d);
    check(d[1] == 1'b0, "R4 filter rejects short pulses", d[1], 0);

    // R12 stop freezes: no further end after clear
    wr(3'd0, 16'd0);
    wr(3'd7, 16'd7);
    repeat (1500) @(negedge clk);
    rd(3'd6, d);
    check(d == 16'd0, "R12 stopped block sets no flags", d, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule